// File: doc/BRIEF.md
# Circular Return Address Stack

This block predicts return targets for a fetch unit. Each call pushes its 32-bit return address. Each return performs a destructive pop, which yields the predicted target in the same cycle. The storage is a circular buffer of `DEPTH` entries, indexed by a single write pointer. A separate occupancy count tracks how many entries hold live data.

The stack never stalls its user. When the stack is full, a push overwrites the oldest entry. When the stack is empty, a pop still steps the pointer back and returns whatever entry it lands on. Each such event increments a 16-bit counter, and these counters stop at their maximum value.

A push and a pop may arrive in the same cycle. The pop is handled first and the push second. If `DEPTH` is zero the stack is disabled: every output stays at zero.

Top module: `ret_addr_stack`

## Requirements
- R1: A push writes its address at the current pointer, and the pointer then advances by one. It wraps from `DEPTH-1` to 0. A run of pushes followed by pops returns the addresses newest first.
- R2: A push alone increments the occupancy when it is below `DEPTH`. When the occupancy equals `DEPTH`, the occupancy stays at `DEPTH`, the overflow counter increments, and the oldest entry is overwritten.
- R3: A pop alone decrements the occupancy when it is nonzero. When the occupancy is zero, the occupancy stays zero and the underflow counter increments.
- R4: A pop moves the pointer back by one, wrapping from 0 to `DEPTH-1`. `pop_addr_o` shows the entry at that new position during the pop cycle. This holds even when the stack is empty, so the wrapped, stale entry is returned.
- R5: After reset, all entries, the pointer, the occupancy and both event counters are zero.
- R6: With `DEPTH` = 0, `pop_addr_o`, the occupancy and both counters read zero whatever the inputs do.
- R7: A push and a pop in the same cycle behave as a pop followed by a push:
  - `pop_addr_o` returns the entry below the pointer as it was before the cycle.
  - That entry is then replaced by the pushed address.
  - The pointer ends where it began.
  - The occupancy is unchanged, except at zero, where it becomes 1 and one underflow is counted.
  - No overflow is counted.
- R8: Each event counter holds at 65535 once it reaches that value.
- R9: The occupancy never exceeds `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_i | input | 1 | Push request (call seen) |
| push_addr_i | input | AW | Return address to push |
| pop_i | input | 1 | Pop request (return seen) |
| pop_addr_o | output | AW | Predicted target, valid in the pop cycle |
| occupancy_o | output | OCC_W | Live entry count, 0..DEPTH |
| ovf_events_o | output | 16 | Saturating count of pushes made while full |
| udf_events_o | output | 16 | Saturating count of pops made while empty |

## Verification
Push and pop are the two functions that can share a cycle. The bench raises both requests together in three states of the stack: empty, partly filled and full.

In each case the predicted target is compared against the entry below the old pointer. The occupancy and both counters are then checked on the next cycle. Further pops show that the pushed address replaced that entry and that the pointer did not move.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int EVT_W = 16;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } ras_op_e;
endpackage

// File: rtl/ras_rst_sync.sv
module ras_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/ras_sat_ctr.sv
module ras_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] val_q, val_n;
  logic         val_en;

  always_comb begin
    val_en = inc && (val_q != TOP);
    val_n  = val_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_n;
  end

  assign value = val_q;

  // R8: once at the top, the value stays there
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q == TOP) |=> (val_q == TOP));
  // R2/R3: an event below the top adds exactly one
  p_evt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && val_q != TOP) |=> (val_q == $past(val_q) + W'(1)));
  p_no_evt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(val_q));
endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3,
  parameter int OCC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx,
  output logic [OCC_W-1:0] occ,
  output logic             ovf_evt,
  output logic             udf_evt
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

  logic [PTR_W-1:0] ptr_q, ptr_n, ptr_inc, ptr_dec;
  logic [OCC_W-1:0] occ_q, occ_n;
  logic             ptr_en, occ_en;
  ras_op_e          op;

  always_comb begin
    op      = ras_op_e'({push, pop});
    ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
    ptr_dec = (ptr_q == '0) ? LAST : ptr_q - PTR_W'(1);
    ptr_n   = ptr_q;
    occ_n   = occ_q;
    ptr_en  = 1'b0;
    occ_en  = 1'b0;
    ovf_evt = 1'b0;
    udf_evt = 1'b0;
    unique case (op)
      OP_PUSH: begin
        ptr_n  = ptr_inc;
        ptr_en = 1'b1;
        if (occ_q == FULL) ovf_evt = 1'b1;
        else begin
          occ_n  = occ_q + OCC_W'(1);
          occ_en = 1'b1;
        end
      end
      OP_POP: begin
        ptr_n  = ptr_dec;
        ptr_en = 1'b1;
        if (occ_q == '0) udf_evt = 1'b1;
        else begin
          occ_n  = occ_q - OCC_W'(1);
          occ_en = 1'b1;
        end
      end
      OP_BOTH: begin
        if (occ_q == '0) begin
          udf_evt = 1'b1;
          occ_n   = OCC_W'(1);
          occ_en  = 1'b1;
        end
      end
      default: ;
    endcase
    wr_idx = pop ? ptr_dec : ptr_q;
    rd_idx = ptr_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (occ_en) occ_q <= occ_n;
  end

  assign occ = occ_q;

  p_occ_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= FULL);
  p_full_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && occ_q == FULL) |=> (occ_q == FULL));
  p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && occ_q == '0) |=> (occ_q == '0));
  p_push_adv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + PTR_W'(1))));
  p_pop_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (ptr_q == (($past(ptr_q) == '0) ? LAST : $past(ptr_q) - PTR_W'(1))));
  p_both_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(ptr_q));
  p_both_no_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |-> !ovf_evt);
endmodule

// File: rtl/ras_storage.sv
module ras_storage #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [AW-1:0]    wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [AW-1:0]    rdata
);
  logic [AW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (waddr == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[i] <= '0;
      else if (ent_en) mem_q[i] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int OCC_W = (DEPTH > 0) ? $clog2(DEPTH + 1) : 1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             push_i,
  input  logic [AW-1:0]    push_addr_i,
  input  logic             pop_i,
  output logic [AW-1:0]    pop_addr_o,
  output logic [OCC_W-1:0] occupancy_o,
  output logic [EVT_W-1:0] ovf_events_o,
  output logic [EVT_W-1:0] udf_events_o
);
  logic rst_n;

  ras_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  if (DEPTH == 0) begin : g_off
    logic unused_in;
    assign unused_in    = ^{push_i, push_addr_i, pop_i, rst_n};
    assign pop_addr_o   = '0;
    assign occupancy_o  = '0;
    assign ovf_events_o = '0;
    assign udf_events_o = '0;
  end else begin : g_on
    logic [PTR_W-1:0] wr_idx, rd_idx;
    logic             ovf_evt, udf_evt;

    ras_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .OCC_W(OCC_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .push(push_i), .pop(pop_i),
      .wr_idx(wr_idx), .rd_idx(rd_idx), .occ(occupancy_o),
      .ovf_evt(ovf_evt), .udf_evt(udf_evt)
    );

    ras_storage #(.DEPTH(DEPTH), .AW(AW), .PTR_W(PTR_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(push_i), .waddr(wr_idx),
      .wdata(push_addr_i), .raddr(rd_idx), .rdata(pop_addr_o)
    );

    ras_sat_ctr #(.W(EVT_W)) u_ovf (.clk(clk), .rst_n(rst_n), .inc(ovf_evt), .value(ovf_events_o));
    ras_sat_ctr #(.W(EVT_W)) u_udf (.clk(clk), .rst_n(rst_n), .inc(udf_evt), .value(udf_events_o));

    // R7: a paired push at zero occupancy leaves one live entry
    p_both_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && occupancy_o == '0) |=> (occupancy_o == OCC_W'(1)));
    // R5: both counters are cleared while the internal reset is held
    p_reset_clear_r5: assert property (@(posedge clk)
      !rst_n |-> (occupancy_o == '0 && ovf_events_o == '0 && udf_events_o == '0));
  end
endmodule

// File: tb/ret_addr_stack_test.sv
module ret_addr_stack_test;
  localparam int D  = 6;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic push = 1'b0, pop = 1'b0;
  logic [AW-1:0] pdata = '0;
  logic [AW-1:0] pop_addr, nil_addr;
  logic [2:0]  occ;
  logic [0:0]  nil_occ;
  logic [15:0] ovf, udf, nil_ovf, nil_udf;

  always #10 clk = ~clk;

  ret_addr_stack #(.DEPTH(D), .AW(AW)) uut (
    .clk(clk), .arst_n(arst_n), .push_i(push), .push_addr_i(pdata), .pop_i(pop),
    .pop_addr_o(pop_addr), .occupancy_o(occ), .ovf_events_o(ovf), .udf_events_o(udf));

  ret_addr_stack #(.DEPTH(0), .AW(AW)) uut_nil (
    .clk(clk), .arst_n(arst_n), .push_i(push), .push_addr_i(pdata), .pop_i(pop),
    .pop_addr_o(nil_addr), .occupancy_o(nil_occ), .ovf_events_o(nil_ovf), .udf_events_o(nil_udf));

  int tests = 0, fails = 0;

  logic [AW-1:0] mdl [D];
  int mptr = 0, mcnt = 0, movf = 0, mudf = 0;

  logic [AW-1:0] exp_q [$];
  string         tag_q [$];
  event          mon_ev;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor: pops the expected target and compares it with the design
  initial forever begin
    @(mon_ev);
    while (exp_q.size() > 0) begin
      automatic logic [AW-1:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(pop_addr == e, t, pop_addr, e);
    end
  end

  // driver: one operation per cycle, entered and left at a falling edge
  task automatic do_op(input bit ps, input bit pp, input logic [AW-1:0] d,
                       input bit check, input string tag);
    logic [AW-1:0] e;
    push = ps; pop = pp; pdata = d;
    if (pp) begin
      mptr = (mptr == 0) ? D - 1 : mptr - 1;
      e = mdl[mptr];
      if (mcnt == 0) begin if (mudf < 65535) mudf++; end
      else mcnt--;
    end
    if (ps) begin
      mdl[mptr] = d;
      mptr = (mptr == D - 1) ? 0 : mptr + 1;
      if (mcnt == D) begin if (movf < 65535) movf++; end
      else mcnt++;
    end
    #5;
    if (pp && check) begin
      exp_q.push_back(e); tag_q.push_back(tag);
      ->mon_ev;
      chk(nil_addr == '0, "R6 pop target", nil_addr, 0);
    end
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
    if (check) begin
      chk(occ == 3'(mcnt), "R2/R3/R9 occupancy", occ, mcnt);
      chk(ovf == 16'(movf), "R2 overflow count", ovf, movf);
      chk(udf == 16'(mudf), "R3 underflow count", udf, mudf);
    end
  endtask

  initial begin
    #3_800_000;
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R5: reset state
    chk(occ == 0, "R5 occupancy", occ, 0);
    chk(ovf == 0 && udf == 0, "R5 counters", {ovf, udf}, 0);
    // R4 R5: empty pops return wrapped zero entries
    do_op(0, 1, '0, 1, "R4 R5 empty pop");
    do_op(0, 1, '0, 1, "R4 R5 empty pop");
    // R1: LIFO order
    do_op(1, 0, 32'h1000_0004, 1, "R1");
    do_op(1, 0, 32'h2000_0008, 1, "R1");
    do_op(1, 0, 32'h3000_000C, 1, "R1");
    do_op(0, 1, '0, 1, "R1 lifo");
    do_op(0, 1, '0, 1, "R1 lifo");
    do_op(0, 1, '0, 1, "R1 lifo");
    // R2: overflow wraps over oldest
    for (int i = 0; i < D + 2; i++) do_op(1, 0, 32'hA000_0000 + i, 1, "R2");
    // R4: pop past empty returns stale wrapped entry
    for (int i = 0; i < D + 2; i++) do_op(0, 1, '0, 1, "R4 wrap pop");
    // R7: paired at empty, partly filled, full
    do_op(1, 1, 32'hB000_0001, 1, "R7 empty pair");
    do_op(1, 0, 32'hB000_0002, 1, "R7");
    do_op(1, 1, 32'hB000_0003, 1, "R7 mid pair");
    for (int i = 0; i < D; i++) do_op(1, 0, 32'hC000_0000 + i, 1, "R7 fill");
    do_op(1, 1, 32'hB000_0004, 1, "R7 full pair");
    for (int i = 0; i < D; i++) do_op(0, 1, '0, 1, "R7 drain");
    // R8: saturation of both counters
    for (int i = 0; i < 65540; i++) do_op(0, 1, '0, 0, "R8");
    chk(udf == 16'hFFFF, "R8 underflow saturate", udf, 16'hFFFF);
    for (int i = 0; i < 65545; i++) do_op(1, 0, 32'(i), 0, "R8");
    chk(ovf == 16'hFFFF, "R8 overflow saturate", ovf, 16'hFFFF);
    do_op(1, 0, 32'h5, 1, "R8 hold");
    chk(nil_occ == 0 && nil_ovf == 0 && nil_udf == 0, "R6 disabled state",
        {nil_occ, nil_ovf, nil_udf}, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule